// File: doc/BRIEF.md
# Codec Power-Mode Sequencer

This block decides when a serial voice codec interface is powered up or powered down. It runs on the master clock. One input pin does two jobs. When a clock is running on it, or it is held low, the codec may run. When it is held high, the codec is forced down. The block also watches the transmit and receive frame syncs. A frame-sync rising edge wakes the codec. A long gap with no frame-sync edge puts it back to sleep.

The timeout counts an internal 256 kHz tick, which arrives as a one-cycle enable. It expires after 256 ticks, about 1 ms, with no rising frame-sync edge. After each wake-up, the PCM data output stays high-impedance until the second frame-sync pulse, so a garbage first word never reaches the bus. While the codec is down, the frame-mode detector is held in reset, so it restarts in short-frame mode.

Top module: `codec_pwr_seq`

## Requirements
- R1: After a synchronous reset, `active`, `pcm_oe` and `aout_oe` are 0 and `fdet_rst` is 1.
- R2: If the control pin shows no edge for EDGE_WIN (default 8) cycles while high, the block goes to power-down within EDGE_WIN+3 cycles. While forced, frame-sync pulses do not wake it. A pin that toggles at least once every EDGE_WIN cycles never forces power-down.
- R3: With the pin toggling, or held statically low, a frame-sync pulse wakes the block.
- R4: While down, the first rising edge of `fs_tx` or `fs_rx` sets `active` and `aout_oe` to 1 and `fdet_rst` to 0 on the next clock edge.
- R5: `pcm_oe` stays 0 after the waking pulse. It rises on the clock edge that sees the second frame-sync rising edge after wake-up, and it is 0 whenever `active` is 0.
- R6: While active, the block powers down on the clock edge that takes the 256th `tick` since the last frame-sync rising edge. After 255 such ticks it is still active.
- R7: A frame-sync rising edge restarts the tick count, even when it falls in the same cycle as a tick, and so cancels a pending power-down.
- R8: `fdet_rst` is 1 exactly while the block is powered down. This returns the frame-mode detector to its short-frame default.
- R9: Only rising edges count as frame-sync activity. A frame sync held high does not stop the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| mclk_pd | input | 1 | Combined master-clock / power-down pin, sampled |
| fs_tx | input | 1 | Transmit frame sync |
| fs_rx | input | 1 | Receive frame sync |
| tick | input | 1 | One-cycle 256 kHz timer enable |
| active | output | 1 | 1 when powered up |
| fdet_rst | output | 1 | Reset to the frame-mode detector |
| pcm_oe | output | 1 | Drive enable for the tri-state PCM output |
| aout_oe | output | 1 | Enable for the analog output |

## Verification
The hardest case to reach is a pin that changes from a running clock to a static high while the codec is active. The change must also be told apart from slow toggling that stays inside the window. The bench drives the pin from a switchable toggler and holds it static for longer than the window. It checks that frame syncs are refused while the pin is forced, and accepted again once toggling resumes.

The timeout boundary is approached by sweeping the tick count across 254 to 257. A frame-sync edge is also placed in the same cycle as a tick, to show that the restart wins over the count.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;

    typedef enum logic [1:0] {
        PS_DOWN = 2'd0,
        PS_WAKE = 2'd1,
        PS_RUN  = 2'd2
    } pwr_state_e;

    typedef struct packed {
        logic clocked;
        logic level;
    } pin_stat_t;

    function automatic logic pin_forces_down(pin_stat_t s);
        return !s.clocked && s.level;
    endfunction

endpackage

// File: rtl/pin_classifier.sv
module pin_classifier
    import codec_pwr_pkg::*;
#(
    parameter int EDGE_WIN = 8
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin,
    output pin_stat_t stat
);
    localparam int WW = $clog2(EDGE_WIN + 1);
    localparam logic [WW-1:0] WLAST = WW'(EDGE_WIN - 1);

    logic          pin_d;
    logic [WW-1:0] win_cnt;
    logic          edge_seen;

    assign edge_seen = pin ^ pin_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_d   <= 1'b0;
            win_cnt <= '0;
            stat    <= '{clocked: 1'b0, level: 1'b0};
        end else begin
            pin_d <= pin;
            if (edge_seen) begin
                win_cnt      <= '0;
                stat.clocked <= 1'b1;
            end else if (win_cnt == WLAST) begin
                win_cnt      <= '0;
                stat.clocked <= 1'b0;
                stat.level   <= pin_d;
            end else begin
                win_cnt <= win_cnt + 1'b1;
            end
        end
    end

    AST_EDGE_MARKS_CLOCK: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> stat.clocked); // R2
endmodule

// File: rtl/fs_watch.sv
module fs_watch #(
    parameter int TMO_TICKS = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fs_tx,
    input  logic fs_rx,
    input  logic tick,
    output logic fs_rise,
    output logic timeout
);
    localparam int CW = $clog2(TMO_TICKS);
    localparam logic [CW-1:0] CLAST = CW'(TMO_TICKS - 1);

    logic          tx_d, rx_d;
    logic [CW-1:0] cnt;

    assign fs_rise = (fs_tx & ~tx_d) | (fs_rx & ~rx_d);
    assign timeout = run && tick && !fs_rise && (cnt == CLAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_d <= 1'b0;
            rx_d <= 1'b0;
            cnt  <= '0;
        end else begin
            tx_d <= fs_tx;
            rx_d <= fs_rx;
            if (fs_rise || !run)
                cnt <= '0;
            else if (tick)
                cnt <= (cnt == CLAST) ? '0 : cnt + 1'b1;
        end
    end

    AST_RISE_CLEARS_COUNT: assert property (@(posedge clk) disable iff (rst)
        fs_rise |=> cnt == '0); // R7
    AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0); // R6
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import codec_pwr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       force_down,
    input  logic       fs_rise,
    input  logic       timeout,
    output pwr_state_e state
);
    pwr_state_e nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            PS_DOWN: if (fs_rise && !force_down) nxt = PS_WAKE;
            PS_WAKE: if (force_down || timeout) nxt = PS_DOWN;
                     else if (fs_rise)          nxt = PS_RUN;
            PS_RUN:  if (force_down || timeout) nxt = PS_DOWN;
            default: nxt = PS_DOWN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= PS_DOWN;
        else     state <= nxt;
    end

    AST_FORCE_HOLDS_DOWN: assert property (@(posedge clk) disable iff (rst)
        force_down |=> state == PS_DOWN); // R2
    AST_STAY_DOWN_NO_FS: assert property (@(posedge clk) disable iff (rst)
        (state == PS_DOWN && !fs_rise) |=> state == PS_DOWN); // R4
    AST_RUN_NEEDS_SECOND: assert property (@(posedge clk) disable iff (rst)
        (state == PS_DOWN) |=> state != PS_RUN); // R5
    AST_TIMEOUT_DOWN: assert property (@(posedge clk) disable iff (rst)
        timeout |=> state == PS_DOWN); // R6
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
    import codec_pwr_pkg::*;
#(
    parameter int EDGE_WIN  = 8,
    parameter int TMO_TICKS = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic mclk_pd,
    input  logic fs_tx,
    input  logic fs_rx,
    input  logic tick,
    output logic active,
    output logic fdet_rst,
    output logic pcm_oe,
    output logic aout_oe
);
    pin_stat_t  pstat;
    pwr_state_e state;
    logic       fs_rise, timeout, run;

    assign run = (state != PS_DOWN);

    pin_classifier #(.EDGE_WIN(EDGE_WIN)) u_pin (
        .clk(clk), .rst(rst), .pin(mclk_pd), .stat(pstat)
    );

    fs_watch #(.TMO_TICKS(TMO_TICKS)) u_fs (
        .clk(clk), .rst(rst), .run(run), .fs_tx(fs_tx), .fs_rx(fs_rx),
        .tick(tick), .fs_rise(fs_rise), .timeout(timeout)
    );

    pwr_fsm u_fsm (
        .clk(clk), .rst(rst), .force_down(pin_forces_down(pstat)),
        .fs_rise(fs_rise), .timeout(timeout), .state(state)
    );

    assign active   = run;
    assign aout_oe  = run;
    assign fdet_rst = !run;
    assign pcm_oe   = (state == PS_RUN);

    AST_PCM_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        pcm_oe |-> active); // R5
    AST_FDET_WHILE_DOWN: assert property (@(posedge clk) disable iff (rst)
        fdet_rst |-> !pcm_oe && !aout_oe); // R8
endmodule

// File: tb/test_codec_pwr_seq.sv
module test_codec_pwr_seq;
    logic clk = 1'b0;
    logic rst, mclk_pd, fs_tx, fs_rx, tick;
    logic active, fdet_rst, pcm_oe, aout_oe;
    logic pin_clk = 1'b0;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;
    always @(negedge clk) if (pin_clk) mclk_pd = ~mclk_pd;

    codec_pwr_seq i_codec_pwr_seq (
        .clk(clk), .rst(rst), .mclk_pd(mclk_pd), .fs_tx(fs_tx), .fs_rx(fs_rx),
        .tick(tick), .active(active), .fdet_rst(fdet_rst),
        .pcm_oe(pcm_oe), .aout_oe(aout_oe)
    );

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse(int src);
        if (src != 1) fs_tx = 1'b1;
        if (src != 0) fs_rx = 1'b1;
        step(1);
        fs_tx = 1'b0; fs_rx = 1'b0;
        step(1);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1; step(1); tick = 1'b0; step(1);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: got hang expected completion");
        finish_run();
    end

    initial begin
        rst = 1'b1; mclk_pd = 1'b0; fs_tx = 1'b0; fs_rx = 1'b0; tick = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        // R1 / R8 reset state
        chk("R1 active", active, 1'b0);
        chk("R1 pcm_oe", pcm_oe, 1'b0);
        chk("R1 aout_oe", aout_oe, 1'b0);
        chk("R8 fdet_rst", fdet_rst, 1'b1);
        step(12);
        // R4 first pulse wakes, R5 output held
        pulse(0);
        chk("R4 active", active, 1'b1);
        chk("R4 aout_oe", aout_oe, 1'b1);
        chk("R8 fdet_rst low", fdet_rst, 1'b0);
        chk("R5 held after first", pcm_oe, 1'b0);
        pulse(1);
        chk("R5 enabled after second", pcm_oe, 1'b1);

        // R6 sweep across the timeout boundary, for each frame-sync source
        for (int src = 0; src < 3; src++) begin
            for (int n = 254; n <= 257; n++) begin
                if (!active) begin pulse(src); pulse(src); end
                pulse(src);
                ticks(n);
                chk("R6 active vs tick count", active, logic'(n < 256));
                chk("R6 pcm_oe vs tick count", pcm_oe, logic'(n < 256));
                chk("R8 fdet_rst vs tick count", fdet_rst, logic'(n >= 256));
            end
        end

        // R7 cancel, including a rise in the same cycle as a tick
        if (!active) begin pulse(0); pulse(0); end
        pulse(1);
        ticks(200);
        pulse(0);
        ticks(255);
        chk("R7 restart keeps active", active, 1'b1);
        fs_rx = 1'b1; tick = 1'b1; step(1);
        fs_rx = 1'b0; tick = 1'b0; step(1);
        ticks(255);
        chk("R7 same-cycle tick restarts", active, 1'b1);
        ticks(1);
        chk("R7 expiry after restart", active, 1'b0);

        // R9 level held high is not activity
        pulse(0); pulse(0);
        fs_tx = 1'b1; step(1);
        ticks(255);
        chk("R9 still active at 255", active, 1'b1);
        ticks(1);
        chk("R9 held high times out", active, 1'b0);
        fs_tx = 1'b0; step(2);

        // R2 static high forces down
        pulse(1);
        pulse(1);
        chk("R5 run before force", pcm_oe, 1'b1);
        mclk_pd = 1'b1;
        step(11);
        chk("R2 forced down", active, 1'b0);
        chk("R2 pcm_oe off", pcm_oe, 1'b0);
        pulse(0);
        chk("R2 fs ignored while forced", active, 1'b0);
        chk("R8 fdet_rst while forced", fdet_rst, 1'b1);

        // R3 clocked pin permits wake; R2 toggling never forces
        pin_clk = 1'b1;
        step(4);
        pulse(0);
        chk("R3 wake with clocked pin", active, 1'b1);
        chk("R5 held after rewake", pcm_oe, 1'b0);
        step(40);
        chk("R2 toggling does not force", active, 1'b1);
        pulse(1);
        chk("R5 enabled after rewake second", pcm_oe, 1'b1);

        // R3 static low permits operation and wake
        pin_clk = 1'b0; mclk_pd = 1'b0;
        step(15);
        chk("R3 static low stays active", active, 1'b1);
        ticks(256);
        chk("R6 down before static-low wake", active, 1'b0);
        pulse(1);
        chk("R3 wake with static low", active, 1'b1);

        finish_run();
    end
endmodule